// File: doc/BRIEF.md
# Fuse-Programmed Sum-of-Products Logic Array

This block is a small programmable AND-OR array. Its behaviour is set entirely by a bit vector of fuses held in flops. Sixteen input signals each produce a true line and a complement line, which gives 32 literal lines. Each of the eight outputs owns a group of eight product terms. The first term of a group gates the output driver. The other seven are ORed into a sum, which then passes a per-output polarity stage and an inverting three-state driver.

Fuses are written one bit per clock through a simple address/data/write-enable port. The logic evaluation from inputs to outputs is purely combinational. The output pad is modelled as a value plus a drive-enable flag. When the enable flag is low, the value is held at 0.

Top module: `pal_sop_array`

## Requirements
- R1: Fuse address = product-line number × 32 + literal index. Literal index 2i is input i true, and 2i+1 is input i complemented.
- R2: Output k owns product lines 8k to 8k+7. Line 8k is its enable term and lines 8k+1 to 8k+7 are ORed into its sum. Programming one group leaves the other outputs unchanged.
- R3: A fuse value of 1 (blown) removes its literal from the term, and 0 (intact) keeps it in the AND. A term with all fuses blown is 1, and a term with all fuses intact is 0.
- R4: `out_oe[k]` equals output k's enable term. With every enable fuse blown the output is always driven. With every enable fuse intact it is never driven. With only some fuses intact it follows the kept literals.
- R5: The polarity fuse of output k is at address 2048+k. When it is intact (0), a driven output shows the inverted sum. When it is blown (1), the output shows the sum.
- R6: While `out_oe[k]` is 0, `out_val[k]` is 0.
- R7: Reset clears every fuse to intact, so no output is driven after reset.
- R8: A write with `fuse_we`=1 and an address below 2056 updates that one fuse at the clock edge. The outputs reflect it after that edge. A write to an address of 2056 or more changes nothing.
- R9: With `fuse_we`=0, the fuse contents hold whatever the address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for fuse writes |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fuse_we | input | 1 | Fuse write strobe |
| fuse_addr | input | 12 | Fuse address |
| fuse_data | input | 1 | Fuse value to write (1 = blown) |
| in_sig | input | 16 | Logic inputs |
| out_val | output | 8 | Output pad values (0 when not driven) |
| out_oe | output | 8 | Output pad drive enables |

## Verification
The bench builds the array with its default sizes: 16 inputs, 8 outputs and 8 terms per output, which gives 2056 fuses and a 12-bit address. With these sizes the whole array is addressable, including the polarity fuses above the main array and the unused addresses from 2056 up to 4095. That makes out-of-range writes observable. They are aimed at addresses whose low bits would hit a live fuse if the design wrapped them. A shadow fuse image evaluated from the requirements is compared with every output across directed cases and a pseudo-random input sweep.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned DEF_N_IN  = 16;
  localparam int unsigned DEF_N_OUT = 8;
  localparam int unsigned DEF_TERMS = 8;

  typedef enum logic {
    LIT_TRUE = 1'b0,
    LIT_COMP = 1'b1
  } lit_pol_e;

  function automatic int unsigned lit_index(input int unsigned sig, input lit_pol_e pol);
    return 2 * sig + ((pol == LIT_COMP) ? 1 : 0);
  endfunction
endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
  parameter int unsigned FUSES = 2056,
  parameter int unsigned AW    = 12
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             data_i,
  output logic [FUSES-1:0] fuse_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [FUSES-1:0] fuse_q;
  logic [FUSES-1:0] fuse_d;
  logic             wr_hit;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign wr_hit = we_i && (32'(addr_i) < FUSES);

  always_comb begin
    fuse_d = fuse_q;
    if (wr_hit) fuse_d[addr_i] = data_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  fuse_q <= '0;
    else if (wr_hit)  fuse_q <= fuse_d;
  end

  assign fuse_o = fuse_q;

  // R8: an in-range write lands in the addressed fuse
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we_i && (32'(addr_i) < FUSES)) |=> (fuse_q[$past(addr_i)] == $past(data_i)));
  // R8: an out-of-range write changes nothing
  a_r8_oob_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we_i && (32'(addr_i) >= FUSES)) |=> $stable(fuse_q));
  // R9: no strobe, no change
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !we_i |=> $stable(fuse_q));
endmodule

// File: rtl/pal_term_group.sv
module pal_term_group #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned TERMS   = 8
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic [N_LINES-1:0]         lines_i,
  input  logic [TERMS*N_LINES-1:0]   fuses_i,
  output logic                       en_o,
  output logic                       sum_o
);
  logic [TERMS-1:0] term;

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    logic [N_LINES-1:0] row;
    assign row     = fuses_i[t*N_LINES +: N_LINES];
    assign term[t] = &(row | lines_i);

    // R3: an all-intact term holds a literal and its complement, so it is 0
    a_r3_intact_zero: assert property (@(posedge clk) disable iff (!rst_ni)
      (row == '0) |-> !term[t]);
    // R3: an all-blown term has no literal left, so it is 1
    a_r3_blown_one: assert property (@(posedge clk) disable iff (!rst_ni)
      (&row) |-> term[t]);
  end

  assign en_o  = term[0];
  assign sum_o = |term[TERMS-1:1];
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell (
  input  logic clk,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sum_i,
  input  logic pol_i,
  output logic val_o,
  output logic oe_o
);
  logic xor_q;
  logic drive;

  assign xor_q = sum_i ^ pol_i;
  assign drive = ~xor_q;
  assign oe_o  = en_i;
  assign val_o = en_i ? drive : 1'b0;

  // R5: intact polarity fuse gives the inverted sum
  a_r5_intact_inverts: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && !pol_i) |-> (val_o == !sum_i));
  // R5: blown polarity fuse gives the sum
  a_r5_blown_follows: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && pol_i) |-> (val_o == sum_i));
  // R6: undriven pad reads 0
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_ni)
    !oe_o |-> !val_o);
endmodule

// File: rtl/pal_sop_array.sv
module pal_sop_array
  import pal_pkg::*;
#(
  parameter  int unsigned N_IN    = DEF_N_IN,
  parameter  int unsigned N_OUT   = DEF_N_OUT,
  parameter  int unsigned TERMS   = DEF_TERMS,
  localparam int unsigned N_LINES = 2 * N_IN,
  localparam int unsigned GROUP   = TERMS * N_LINES,
  localparam int unsigned ARRAY   = N_OUT * GROUP,
  localparam int unsigned FUSES   = ARRAY + N_OUT,
  localparam int unsigned AW      = $clog2(FUSES)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             fuse_we,
  input  logic [AW-1:0]    fuse_addr,
  input  logic             fuse_data,
  input  logic [N_IN-1:0]  in_sig,
  output logic [N_OUT-1:0] out_val,
  output logic [N_OUT-1:0] out_oe
);
  logic [FUSES-1:0]   fuses;
  logic [N_LINES-1:0] lines;

  pal_fuse_store #(.FUSES(FUSES), .AW(AW)) u_store (
    .clk    (clk),
    .rst_ni (rst_ni),
    .we_i   (fuse_we),
    .addr_i (fuse_addr),
    .data_i (fuse_data),
    .fuse_o (fuses)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lines[lit_index(i, LIT_TRUE)] = in_sig[i];
    assign lines[lit_index(i, LIT_COMP)] = ~in_sig[i];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic en;
    logic sum;

    pal_term_group #(.N_LINES(N_LINES), .TERMS(TERMS)) u_group (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .lines_i (lines),
      .fuses_i (fuses[k*GROUP +: GROUP]),
      .en_o    (en),
      .sum_o   (sum)
    );

    pal_out_cell u_cell (
      .clk    (clk),
      .rst_ni (rst_ni),
      .en_i   (en),
      .sum_i  (sum),
      .pol_i  (fuses[ARRAY + k]),
      .val_o  (out_val[k]),
      .oe_o   (out_oe[k])
    );
  end
endmodule

// File: tb/pal_sop_array_tb.sv
`timescale 1ns/1ps
module pal_sop_array_tb;
  localparam int NF = 2056;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        fuse_we;
  logic [11:0] fuse_addr;
  logic        fuse_data;
  logic [15:0] in_sig;
  logic [7:0]  out_val;
  logic [7:0]  out_oe;

  int errors = 0;
  int checks = 0;
  bit sh [0:NF-1];

  always #2.5 clk = ~clk;

  pal_sop_array u_dut (
    .clk(clk), .rst_ni(rst_ni), .fuse_we(fuse_we), .fuse_addr(fuse_addr),
    .fuse_data(fuse_data), .in_sig(in_sig), .out_val(out_val), .out_oe(out_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected outputs computed from the requirement text (R1..R6)
  task automatic model(input logic [15:0] x, output logic [7:0] v, output logic [7:0] oe);
    for (int k = 0; k < 8; k++) begin
      logic en, sum;
      en = 1'b0; sum = 1'b0;
      for (int t = 0; t < 8; t++) begin
        logic term;
        term = 1'b1;
        for (int j = 0; j < 32; j++) begin
          logic lit;
          lit = (j % 2 == 0) ? x[j/2] : ~x[j/2];
          if (!sh[(k*8+t)*32+j] && !lit) term = 1'b0;
        end
        if (t == 0) en = term; else sum = sum | term;
      end
      oe[k] = en;
      v[k]  = en ? (sh[2048+k] ? sum : ~sum) : 1'b0;
    end
  endtask

  task automatic apply(input logic [15:0] x);
    in_sig = x;
    #1;
  endtask

  task automatic check_model(input string req);
    logic [7:0] ev, eo;
    model(in_sig, ev, eo);
    chk(out_val == ev, req, {8'h0, out_val}, {8'h0, ev});
    chk(out_oe == eo, req, {8'h0, out_oe}, {8'h0, eo});
  endtask

  task automatic wr(input int a, input bit d);
    @(negedge clk);
    fuse_we = 1'b1; fuse_addr = 12'(a); fuse_data = d;
    @(negedge clk);
    fuse_we = 1'b0;
    if (a < NF) sh[a] = d;
  endtask

  task automatic blow_line(input int line);
    for (int j = 0; j < 32; j++) wr(line*32 + j, 1'b1);
  endtask

  task automatic t_reset;
    for (int p = 0; p < 3; p++) begin
      apply(16'(p * 16'h5A5A));
      chk(out_oe == 8'h00, "R7 no drive after reset", {8'h0, out_oe}, 16'h0);
      chk(out_val == 8'h00, "R6 idle value", {8'h0, out_val}, 16'h0);
    end
  endtask

  task automatic t_enable_out0;
    blow_line(0);
    apply(16'h0000);
    chk(out_oe == 8'h01, "R4 all-blown enable drives", {8'h0, out_oe}, 16'h1);
    chk(out_val[0] == 1'b1, "R5 intact polarity inverts empty sum", {15'h0, out_val[0]}, 16'h1);
  endtask

  task automatic t_and_term;
    blow_line(1);
    wr(32 + 0, 1'b0);
    wr(32 + 2, 1'b0);
    for (int p = 0; p < 4; p++) begin
      apply(16'(p));
      chk(out_val[0] == ~(in_sig[0] & in_sig[1]), "R1 R3 active-low AND",
          {15'h0, out_val[0]}, {15'h0, ~(in_sig[0] & in_sig[1])});
      check_model("R3 model");
    end
  endtask

  task automatic t_polarity;
    wr(2048, 1'b1);
    for (int p = 0; p < 4; p++) begin
      apply(16'(p));
      chk(out_val[0] == (in_sig[0] & in_sig[1]), "R5 blown polarity",
          {15'h0, out_val[0]}, {15'h0, in_sig[0] & in_sig[1]});
    end
  endtask

  task automatic t_group1;
    blow_line(8);
    blow_line(9);  wr(9*32 + 4, 1'b0);  wr(9*32 + 7, 1'b0);
    blow_line(10); wr(10*32 + 5, 1'b0); wr(10*32 + 6, 1'b0);
    wr(2049, 1'b1);
    for (int p = 0; p < 4; p++) begin
      apply(16'(p << 2) | 16'h0003);
      chk(out_val[1] == (in_sig[2] ^ in_sig[3]), "R2 R1 XOR on output 1",
          {15'h0, out_val[1]}, {15'h0, in_sig[2] ^ in_sig[3]});
      chk(out_val[0] == 1'b1, "R2 output 0 unchanged", {15'h0, out_val[0]}, 16'h1);
    end
  endtask

  task automatic t_enable_term;
    blow_line(56);
    wr(56*32 + 30, 1'b0);
    apply(16'h0000);
    chk(out_oe[7] == 1'b0, "R4 enable term follows input low", {15'h0, out_oe[7]}, 16'h0);
    chk(out_val[7] == 1'b0, "R6 undriven value", {15'h0, out_val[7]}, 16'h0);
    apply(16'h8000);
    chk(out_oe[7] == 1'b1, "R4 enable term follows input high", {15'h0, out_oe[7]}, 16'h1);
    chk(out_val[7] == 1'b1, "R5 driven empty sum", {15'h0, out_val[7]}, 16'h1);
  endtask

  task automatic t_oob;
    apply(16'h0003);
    wr(2048 + 32 + 4, 1'b0);
    wr(4095, 1'b1);
    wr(2056, 1'b1);
    apply(16'h0003);
    chk(out_val[0] == 1'b1, "R8 out-of-range write ignored", {15'h0, out_val[0]}, 16'h1);
    check_model("R8 model");
  endtask

  task automatic t_no_we;
    @(negedge clk);
    fuse_addr = 12'd36; fuse_data = 1'b0; fuse_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    apply(16'h0003);
    chk(out_val[0] == 1'b1, "R9 idle port holds fuses", {15'h0, out_val[0]}, 16'h1);
  endtask

  task automatic t_sweep;
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int p = 0; p < 40; p++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      apply(lf);
      check_model("R2 R3 R5 sweep");
    end
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NF; i++) sh[i] = 1'b0;
    rst_ni = 1'b0; fuse_we = 1'b0; fuse_addr = '0; fuse_data = 1'b0; in_sig = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_enable_out0;
    t_and_term;
    t_polarity;
    t_group1;
    t_enable_term;
    t_oob;
    t_no_we;
    t_sweep;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule